// File: doc/BRIEF.md
# Sequence-Protected Flash Rewrite Control Register

This block is one 8-bit control register that sits on a simple CPU bus and steers a flash rewrite sequencer. It holds an erase/write mode select bit and one rewrite-disable bit per flash block. None of these bits can be changed by a plain store. The mode bit is raised only by a write of 0 followed at once by a write of 1. A disable bit is lowered only by a write of 1 followed at once by a write of 0. Both sequences require the CPU-rewrite-enable input to be held high.

Each protected bit has its own small tracker that remembers whether the previous write to the register opened its sequence. Three things cancel an open sequence: a write to the register that does not complete it, a dropped rewrite-enable level, or an interrupt-taken pulse. Reads are combinational and have no side effects. Writes to other addresses are not seen by the block.

Top module: `flash_rewrite_ctl_reg`

## Requirements
- R1: After reset the register reads 0x80, `ew_mode_o` is 0 and every `blk_dis_o` bit is 0.
- R2: The bit layout is fixed. Bit 7 always reads 1. Bits 6, 3, 2 and 0 always read 0, whatever was written to them. The mode bit is bit 1, the block 0 disable bit is bit 4 and the block 1 disable bit is bit 5.
- R3: With rewrite enable high, a register write with bit 1 = 0 clears the mode bit and opens its sequence. If the next register write has bit 1 = 1, the mode bit becomes 1 at that clock edge.
- R4: A register write with bit 1 = 1 and no open mode sequence leaves the mode bit unchanged.
- R5: While rewrite enable is low, the mode bit is 0 from the next edge on, and any open sequence is dropped.
- R6: With rewrite enable high, a register write with a disable bit = 1 sets that disable bit and opens its clear sequence.
- R7: A disable bit clears only when a write with that bit = 0 immediately follows a write with that bit = 1. A lone write of 0 leaves the bit set.
- R8: While rewrite enable is low, writes do not change any disable bit, and open clear sequences are dropped.
- R9: An `irq_taken` pulse drops every open sequence. If the pulse falls in the same cycle as a register write, that write still performs its direct action (clear mode, set disable), but it neither completes nor opens any sequence.
- R10: Reads, idle cycles and writes to other addresses change no bit and cancel no sequence. `bus_rdata` is 0 unless a read of the register's address is strobed.
- R11: `bus_rdata` shows the current contents combinationally in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rewrite_en | input | 1 | CPU rewrite enable level |
| irq_taken | input | 1 | One-cycle pulse when an interrupt is accepted |
| ew_mode_o | output | 1 | Erase/write mode select |
| blk_dis_o | output | NUM_BLK | Per-block rewrite disable |

## Verification
An interrupt-taken pulse can land in the same cycle as the register write that would complete a sequence or open one. The bench provokes this directly. It opens the mode sequence and then issues the completing write together with the pulse. It also pairs an arming write with the pulse and follows it with the completing value. In both cases the bench expects the mode bit to stay 0. Random stimulus raises `irq_taken` on about one cycle in eight alongside register writes, so these collisions recur on every tracker. Each result is judged against a bench model of the sequence rules.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

   localparam int REG_W       = 8;
   localparam int MODE_POS    = 1;
   localparam int BLK_LSB     = 4;
   localparam int BLK_MAX     = 2;
   localparam int RSV_ONE_POS = 7;

   typedef enum logic {
      ARM_ON_ZERO = 1'b0,
      ARM_ON_ONE  = 1'b1
   } arm_pol_e;

endpackage

// File: rtl/flash_reg_decode.sv
module flash_reg_decode #(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic              wr_hit,
   output logic              rd_hit
);

   logic sel;

   always_comb begin
      sel    = (bus_addr == REG_ADDR);
      wr_hit = sel & bus_wr;
      rd_hit = sel & bus_rd;
   end

endmodule

// File: rtl/flash_seq_bit.sv
module flash_seq_bit
   import flash_ctl_pkg::*;
#(
   parameter arm_pol_e ARM_POL   = ARM_ON_ZERO,
   parameter bit       FORCE_OFF = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rewrite_en,
   input  logic wr_hit,
   input  logic wr_bit,
   input  logic abort,
   output logic bit_q
);

   localparam logic ARM_V = logic'(ARM_POL);

   logic armed;
   logic q_nxt;
   logic armed_nxt;

   always_comb begin
      q_nxt     = bit_q;
      armed_nxt = armed;
      if (!rewrite_en) begin
         armed_nxt = 1'b0;
         if (FORCE_OFF) q_nxt = 1'b0;
      end else if (wr_hit) begin
         if (wr_bit == ARM_V) begin
            q_nxt     = ARM_V;
            armed_nxt = ~abort;
         end else begin
            if (armed && !abort) q_nxt = ~ARM_V;
            armed_nxt = 1'b0;
         end
      end else if (abort) begin
         armed_nxt = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= 1'b0;
         armed <= 1'b0;
      end else begin
         bit_q <= q_nxt;
         armed <= armed_nxt;
      end
   end

   // R9
   abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !armed);

   // R4
   lone_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rewrite_en && wr_hit && (wr_bit != ARM_V) && !armed) |=> $stable(bit_q));

   // R6
   direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rewrite_en && wr_hit && (wr_bit == ARM_V)) |=> (bit_q == ARM_V));

   generate
      if (FORCE_OFF) begin : g_force
         // R5
         en_low_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rewrite_en |=> !bit_q);
      end else begin : g_hold
         // R8
         en_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rewrite_en |=> $stable(bit_q));
      end
   endgenerate

endmodule

// File: rtl/flash_reg_readback.sv
module flash_reg_readback
   import flash_ctl_pkg::*;
#(
   parameter int NUM_BLK = 2
) (
   input  logic               rd_hit,
   input  logic               ew_mode,
   input  logic [NUM_BLK-1:0] blk_dis,
   output logic [REG_W-1:0]   rdata
);

   logic [REG_W-1:0] image;

   always_comb begin
      image              = '0;
      image[RSV_ONE_POS] = 1'b1;
      image[MODE_POS]    = ew_mode;
      for (int i = 0; i < NUM_BLK; i++) begin
         image[BLK_LSB+i] = blk_dis[i];
      end
      rdata = rd_hit ? image : '0;
   end

endmodule

// File: rtl/flash_rewrite_ctl_reg.sv
module flash_rewrite_ctl_reg
   import flash_ctl_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'h35,
   parameter int NUM_BLK = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic               rewrite_en,
   input  logic               irq_taken,
   output logic               ew_mode_o,
   output logic [NUM_BLK-1:0] blk_dis_o
);

   localparam logic [REG_W-1:0] RSV_ZERO_MASK = 8'b0100_1101;

   generate
      if (NUM_BLK < 1 || NUM_BLK > BLK_MAX) begin : g_bad_blk
         $error("NUM_BLK must lie in 1..2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be positive");
      end
   endgenerate

   logic wr_hit;
   logic rd_hit;
   logic rsv_wr_bits_unused;

   assign rsv_wr_bits_unused = ^{bus_wdata[7:6], bus_wdata[3:2], bus_wdata[0]};

   flash_reg_decode #(
      .ADDR_W  (ADDR_W),
      .REG_ADDR(REG_ADDR)
   ) i_decode (
      .bus_addr(bus_addr),
      .bus_wr  (bus_wr),
      .bus_rd  (bus_rd),
      .wr_hit  (wr_hit),
      .rd_hit  (rd_hit)
   );

   flash_seq_bit #(
      .ARM_POL  (ARM_ON_ZERO),
      .FORCE_OFF(1'b1)
   ) i_mode_bit (
      .clk       (clk),
      .rst_n     (rst_n),
      .rewrite_en(rewrite_en),
      .wr_hit    (wr_hit),
      .wr_bit    (bus_wdata[MODE_POS]),
      .abort     (irq_taken),
      .bit_q     (ew_mode_o)
   );

   generate
      for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
         flash_seq_bit #(
            .ARM_POL  (ARM_ON_ONE),
            .FORCE_OFF(1'b0)
         ) i_dis_bit (
            .clk       (clk),
            .rst_n     (rst_n),
            .rewrite_en(rewrite_en),
            .wr_hit    (wr_hit),
            .wr_bit    (bus_wdata[BLK_LSB+b]),
            .abort     (irq_taken),
            .bit_q     (blk_dis_o[b])
         );
      end
      if (NUM_BLK < BLK_MAX) begin : g_unused_blk
         logic unused_blk_wr;
         assign unused_blk_wr = ^bus_wdata[BLK_LSB+BLK_MAX-1:BLK_LSB+NUM_BLK];
      end
   endgenerate

   flash_reg_readback #(
      .NUM_BLK(NUM_BLK)
   ) i_readback (
      .rd_hit (rd_hit),
      .ew_mode(ew_mode_o),
      .blk_dis(blk_dis_o),
      .rdata  (bus_rdata)
   );

   // R10
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !irq_taken && rewrite_en) |=> $stable({ew_mode_o, blk_dis_o}));

   // R2
   rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> (bus_rdata[RSV_ONE_POS] && ((bus_rdata & RSV_ZERO_MASK) == '0)));

   // R10
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (bus_rdata == '0));

endmodule

// File: tb/test_flash_rewrite_ctl_reg.sv
`timescale 1ns/100ps
module test_flash_rewrite_ctl_reg;

   localparam logic [7:0] REG   = 8'h35;
   localparam logic [7:0] OTHER = 8'h36;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = REG;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       rewrite_en = 1'b1;
   logic       irq_taken = 1'b0;
   logic       ew_mode_o;
   logic [1:0] blk_dis_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic       m_mode, m_am;
   logic [1:0] m_d, m_ad;
   logic [7:0] last_rd;
   logic       last_mode;
   logic [1:0] last_blk;

   always #2 clk = ~clk;

   flash_rewrite_ctl_reg #(
      .ADDR_W(8), .REG_ADDR(REG), .NUM_BLK(2)
   ) i_flash_rewrite_ctl_reg (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rewrite_en(rewrite_en), .irq_taken(irq_taken),
      .ew_mode_o(ew_mode_o), .blk_dis_o(blk_dis_o)
   );

   function automatic logic [7:0] exp_image();
      return {1'b1, 1'b0, m_d[1], m_d[0], 2'b00, m_mode, 1'b0};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic model_edge(input logic w, input logic [7:0] a, input logic [7:0] d,
                             input logic e, input logic i);
      if (!e) begin
         m_mode = 1'b0; m_am = 1'b0; m_ad = 2'b00;
      end else if (w && a == REG) begin
         if (!d[1]) begin m_mode = 1'b0; m_am = ~i; end
         else begin if (m_am && !i) m_mode = 1'b1; m_am = 1'b0; end
         for (int k = 0; k < 2; k++) begin
            if (d[4+k]) begin m_d[k] = 1'b1; m_ad[k] = ~i; end
            else begin if (m_ad[k] && !i) m_d[k] = 1'b0; m_ad[k] = 1'b0; end
         end
      end else if (i) begin
         m_am = 1'b0; m_ad = 2'b00;
      end
   endtask

   task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                       input logic e, input logic i);
      bus_wr = w; bus_addr = a; bus_wdata = d; rewrite_en = e; irq_taken = i; bus_rd = 1'b0;
      @(posedge clk);
      model_edge(w, a, d, e, i);
      #1;
      bus_wr = 1'b0; irq_taken = 1'b0; bus_addr = REG; bus_rd = 1'b1;
      #0.5;
      last_rd = bus_rdata; last_mode = ew_mode_o; last_blk = blk_dis_o;
      @(negedge clk);
   endtask

   initial begin
      m_mode = 0; m_am = 0; m_d = 0; m_ad = 0;
      void'($urandom(32'd4242));
      bus_rd = 1'b1;
      repeat (3) @(negedge clk);
      #0.5;
      chk("R1 reset rdata", bus_rdata, 8'h80);
      chk("R1 reset outputs", {ew_mode_o, blk_dis_o}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 mode set sequence
      step(1, REG, 8'h80, 1, 0);
      chk("R3 arm keeps mode 0", last_rd, 8'h80);
      step(1, REG, 8'h82, 1, 0);
      chk("R3 mode set", last_rd, 8'h82);
      chk("R3 mode pin", last_mode, 1'b1);
      // R9 interrupt between the two writes
      step(1, REG, 8'h80, 1, 0);
      step(0, REG, 8'h00, 1, 1);
      step(1, REG, 8'h82, 1, 0);
      chk("R9 irq between", last_rd, 8'h80);
      // R4 lone 1
      step(1, REG, 8'h82, 1, 0);
      chk("R4 lone one", last_rd, 8'h80);
      // R10 other address in between does not cancel
      step(1, REG, 8'h80, 1, 0);
      step(1, OTHER, 8'h82, 1, 0);
      step(1, REG, 8'h82, 1, 0);
      chk("R10 foreign write ignored", last_rd, 8'h82);
      // R5 enable low forces mode 0 and cancels
      step(0, REG, 8'h00, 0, 0);
      chk("R5 forced off", last_mode, 1'b0);
      step(1, REG, 8'h80, 1, 0);
      step(0, REG, 8'h00, 0, 0);
      step(1, REG, 8'h82, 1, 0);
      chk("R5 pending dropped", last_rd, 8'h80);
      // R9 coincident pulse
      step(1, REG, 8'h80, 1, 1);
      step(1, REG, 8'h82, 1, 0);
      chk("R9 arm with irq", last_rd, 8'h80);
      step(1, REG, 8'h80, 1, 0);
      step(1, REG, 8'h82, 1, 1);
      chk("R9 finish with irq", last_rd, 8'h80);
      // R6 disable set
      step(1, REG, 8'h90, 1, 0);
      chk("R6 blk0 set", last_rd, 8'h90);
      chk("R6 blk pins", last_blk, 2'b01);
      // R7 lone 0 after irq
      step(0, REG, 8'h00, 1, 1);
      step(1, REG, 8'h80, 1, 0);
      chk("R7 lone zero", last_rd, 8'h90);
      // R7 clear sequences
      step(1, REG, 8'hB0, 1, 0);
      chk("R6 both set", last_rd, 8'hB0);
      step(1, REG, 8'hA0, 1, 0);
      chk("R7 blk0 cleared", last_rd, 8'hA0);
      step(1, REG, 8'h80, 1, 0);
      chk("R7 blk1 cleared", last_rd, 8'h80);
      // R8 enable low
      step(1, REG, 8'hB0, 0, 0);
      chk("R8 write ignored", last_rd, 8'h80);
      step(1, REG, 8'h90, 1, 0);
      step(0, REG, 8'h00, 0, 0);
      step(1, REG, 8'h80, 1, 0);
      chk("R8 pending dropped", last_rd, 8'h90);
      // R2 reserved bits
      step(1, REG, 8'h4D, 1, 0);
      chk("R2 reserved", last_rd, 8'h90);
      // R11 combinational read, R10 unselected read
      bus_rd = 1'b0; #0.2;
      chk("R10 no strobe", bus_rdata, 8'h00);
      bus_rd = 1'b1; #0.2;
      chk("R11 same cycle", bus_rdata, 8'h90);
      bus_addr = OTHER; #0.2;
      chk("R10 other addr read", bus_rdata, 8'h00);
      bus_addr = REG;
      @(negedge clk);

      for (int n = 0; n < 3000; n++) begin
         logic [7:0] d, a;
         logic w, e, i;
         d = 8'($urandom);
         w = ($urandom % 4) != 0;
         a = (($urandom % 6) == 0) ? OTHER : REG;
         e = ($urandom % 10) != 0;
         i = ($urandom % 8) == 0;
         step(w, a, d, e, i);
         chk("R2 random image", last_rd, exp_image());
         chk("R9 random pins", {last_mode, last_blk}, {m_mode, m_d});
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule